// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a 32-bit physical address by reading two levels of translation tables from memory. The top 12 address bits select a four-byte entry in a 4096-entry directory whose base comes from a base-address input. A valid directory entry points at a 256-entry second-level table, indexed by the next 8 address bits. A valid second-level entry supplies the physical page frame and a 4-bit authority index, and the low 12 bits of the virtual address pass through as the page offset.

A client presents one translation at a time on a valid/ready request port and receives a single-cycle response pulse carrying the physical address, the authority index and two fault flags, one for a bad directory entry and one for a bad second-level entry. Each fault kind also leaves the faulting virtual address in its own register until the next fault of that kind. Table reads go out on a simple read port that keeps one read in flight and holds it until the memory answers. When the enable input is low at acceptance, the walker skips the tables and answers with the address unchanged. Caching of entries and permission enforcement belong to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and both fault address registers read 0.
- R2: The first read of a walk goes to `base_addr + 4 * va[31:20]`, with `base_addr` and `va` taken in the accepting cycle.
- R3: A directory entry is valid only when its bits 1:0 equal 2'b01, and bits 9:2 have no effect. Any other value ends the walk with `rsp_l1_fault`=1, `rsp_pa`=0, `rsp_aci`=0 and no second read, and loads `l1_fault_va` with the virtual address.
- R4: The second read goes to `{dte[31:10], 10'b0} + 4 * va[19:12]`.
- R5: A second-level entry whose bit 1 is 0 ends the walk with `rsp_l2_fault`=1, `rsp_pa`=0 and `rsp_aci`=0. It loads `l2_fault_va` with the virtual address and leaves `l1_fault_va` unchanged.
- R6: A second-level entry whose bit 1 is 1 yields `rsp_pa = {pte[31:12], va[11:0]}` and `rsp_aci = pte[7:4]`, with both fault flags 0. At most one fault flag is set in any response.
- R7: With `en`=0 in the accepting cycle, the response comes in the next cycle with `rsp_pa` equal to the virtual address, `rsp_aci`=0 and no fault. No memory read is issued and both fault registers keep their values.
- R8: `req_ready` is 1 only when no walk is in progress, and a request presented during a walk has no effect on that walk's result.
- R9: A read stays asserted with a stable address until `mem_rd_data_valid`, and the data is taken in that same cycle. If the memory answers each read after L waiting cycles, counting from the accepting edge to the cycle in which `rsp_valid` is 1 gives 1 cycle in bypass, L+2 cycles for a directory fault and 2L+3 cycles otherwise.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | 1 = walk the tables, 0 = pass the address through |
| base_addr | input | 32 | Physical base of the directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Translated physical address (0 on a fault) |
| rsp_aci | output | 4 | Authority index from the second-level entry |
| rsp_l1_fault | output | 1 | Directory entry was not valid |
| rsp_l2_fault | output | 1 | Second-level entry was not valid |
| mem_rd_valid | output | 1 | Table read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_data_valid | input | 1 | Read data is present this cycle |
| mem_rd_data | input | 32 | Table entry read back |
| l1_fault_va | output | 32 | Virtual address of the latest directory fault |
| l2_fault_va | output | 32 | Virtual address of the latest second-level fault |

## Verification
A wrong internal state shows first on the read port. A wrong index extraction or a wrongly kept directory entry puts a wrong address on `mem_rd_addr` in the first cycle of that read. A wrong step count moves `rsp_valid` away from the 1, L+2 or 2L+3 cycle point. The bench serves a synthetic table in which every entry encodes its own indices, so any mix-up of fields appears in `rsp_pa` in the response cycle. Fault registers are compared after every walk, which exposes a capture on the wrong fault kind by the end of the same walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW           = 32;
  localparam int DIR_W        = 12;
  localparam int PT_W         = 8;
  localparam int OFF_W        = 12;
  localparam int ACI_W        = 4;
  localparam int ACI_LSB      = 4;
  localparam int DTE_ADDR_LSB = 10;
  localparam int PTE_VLD_BIT  = 1;
  localparam int ENT_LOG2     = 2;

  localparam logic [AW-1:0] DTE_ADDR_MASK = ~((AW'(1) << DTE_ADDR_LSB) - AW'(1));
  localparam logic [AW-1:0] DTE_ATTR_MASK = AW'(3);
  localparam logic [AW-1:0] DTE_ATTR_OK   = AW'(1);
  localparam logic [AW-1:0] OFF_MASK      = (AW'(1) << OFF_W) - AW'(1);
  localparam logic [AW-1:0] PAGE_MASK     = ~OFF_MASK;
  localparam logic [AW-1:0] PT_IDX_MASK   = (AW'(1) << PT_W) - AW'(1);
  localparam logic [AW-1:0] PTE_VLD_MASK  = AW'(1) << PTE_VLD_BIT;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_PTE, S_RSP} walk_state_e;

  function automatic logic [AW-1:0] f_dte_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] va);
    return base + ((va >> (PT_W + OFF_W)) << ENT_LOG2);
  endfunction

  function automatic logic [AW-1:0] f_pte_addr(input logic [AW-1:0] dte,
                                               input logic [AW-1:0] va);
    return (dte & DTE_ADDR_MASK) + (((va >> OFF_W) & PT_IDX_MASK) << ENT_LOG2);
  endfunction

  function automatic logic f_dte_ok(input logic [AW-1:0] dte);
    return (dte & DTE_ATTR_MASK) == DTE_ATTR_OK;
  endfunction

  function automatic logic f_pte_ok(input logic [AW-1:0] pte);
    return (pte & PTE_VLD_MASK) != '0;
  endfunction

  function automatic logic [AW-1:0] f_phys(input logic [AW-1:0] pte,
                                           input logic [AW-1:0] va);
    return (pte & PAGE_MASK) | (va & OFF_MASK);
  endfunction

  function automatic logic [ACI_W-1:0] f_aci(input logic [AW-1:0] pte);
    return ACI_W'(pte >> ACI_LSB);
  endfunction
endpackage

// File: rtl/ptw_req_latch.sv
module ptw_req_latch
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] va_in,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] walk_va,
  output logic [AW-1:0] walk_base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_va   <= '0;
      walk_base <= '0;
    end else if (fire) begin
      walk_va   <= va_in;
      walk_base <= base_in;
    end
  end
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             walk_en,
  input  logic [AW-1:0]    req_va,
  input  logic [AW-1:0]    walk_va,
  input  logic             rd_dv,
  input  logic [AW-1:0]    rd_data,
  output walk_state_e      state,
  output logic [AW-1:0]    dte_q,
  output logic [AW-1:0]    rsp_pa,
  output logic [ACI_W-1:0] rsp_aci,
  output logic             rsp_l1,
  output logic             rsp_l2,
  output logic             rsp_bypass,
  output logic             l1_hit,
  output logic             l2_hit
);
  logic dir_done, pte_done;

  assign dir_done = (state == S_DIR) && rd_dv;
  assign pte_done = (state == S_PTE) && rd_dv;
  assign l1_hit   = dir_done && !f_dte_ok(rd_data);
  assign l2_hit   = pte_done && !f_pte_ok(rd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      dte_q      <= '0;
      rsp_pa     <= '0;
      rsp_aci    <= '0;
      rsp_l1     <= 1'b0;
      rsp_l2     <= 1'b0;
      rsp_bypass <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (fire) begin
          if (walk_en) begin
            state <= S_DIR;
          end else begin
            state      <= S_RSP;
            rsp_pa     <= req_va;
            rsp_aci    <= '0;
            rsp_l1     <= 1'b0;
            rsp_l2     <= 1'b0;
            rsp_bypass <= 1'b1;
          end
        end
        S_DIR: if (dir_done) begin
          rsp_bypass <= 1'b0;
          if (l1_hit) begin
            state   <= S_RSP;
            rsp_pa  <= '0;
            rsp_aci <= '0;
            rsp_l1  <= 1'b1;
            rsp_l2  <= 1'b0;
          end else begin
            state <= S_PTE;
            dte_q <= rd_data;
          end
        end
        S_PTE: if (pte_done) begin
          state      <= S_RSP;
          rsp_l1     <= 1'b0;
          rsp_bypass <= 1'b0;
          if (l2_hit) begin
            rsp_pa  <= '0;
            rsp_aci <= '0;
            rsp_l2  <= 1'b1;
          end else begin
            rsp_pa  <= f_phys(rd_data, walk_va);
            rsp_aci <= f_aci(rd_data);
            rsp_l2  <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_fault_log.sv
module ptw_fault_log
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l1_hit,
  input  logic          l2_hit,
  input  logic [AW-1:0] walk_va,
  output logic [AW-1:0] l1_va,
  output logic [AW-1:0] l2_va
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_va <= '0;
      l2_va <= '0;
    end else begin
      if (l1_hit) l1_va <= walk_va;
      if (l2_hit) l2_va <= walk_va;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AW-1:0]    base_addr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_va,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_pa,
  output logic [ACI_W-1:0] rsp_aci,
  output logic             rsp_l1_fault,
  output logic             rsp_l2_fault,
  output logic             mem_rd_valid,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [AW-1:0]    mem_rd_data,
  output logic [AW-1:0]    l1_fault_va,
  output logic [AW-1:0]    l2_fault_va
);
  walk_state_e   state;
  logic          fire, l1_hit, l2_hit, rsp_bypass;
  logic [AW-1:0] walk_va, walk_base, dte_q;

  assign req_ready    = (state == S_IDLE);
  assign fire         = req_valid && req_ready;
  assign rsp_valid    = (state == S_RSP);
  assign mem_rd_valid = (state == S_DIR) || (state == S_PTE);
  assign mem_rd_addr  = (state == S_DIR) ? f_dte_addr(walk_base, walk_va)
                                         : f_pte_addr(dte_q, walk_va);

  ptw_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire), .va_in(req_va), .base_in(base_addr),
    .walk_va(walk_va), .walk_base(walk_base)
  );

  ptw_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .walk_en(en), .req_va(req_va),
    .walk_va(walk_va), .rd_dv(mem_rd_data_valid), .rd_data(mem_rd_data),
    .state(state), .dte_q(dte_q), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci),
    .rsp_l1(rsp_l1_fault), .rsp_l2(rsp_l2_fault), .rsp_bypass(rsp_bypass),
    .l1_hit(l1_hit), .l2_hit(l2_hit)
  );

  ptw_fault_log u_flt (
    .clk(clk), .rst_n(rst_n), .l1_hit(l1_hit), .l2_hit(l2_hit),
    .walk_va(walk_va), .l1_va(l1_fault_va), .l2_va(l2_fault_va)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_pa,
  input logic          rsp_l1_fault,
  input logic          rsp_l2_fault,
  input logic          mem_rd_valid,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_data_valid,
  input logic [AW-1:0] l1_fault_va,
  input logic [AW-1:0] l2_fault_va,
  input logic [AW-1:0] walk_va,
  input logic          rsp_bypass
);
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || rsp_valid) |-> !req_ready);

  p_read_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_data_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_one_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_l1_fault && rsp_l2_fault));

  p_l1_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_l1_fault) |-> (l1_fault_va == walk_va && rsp_pa == '0));

  p_l2_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_l2_fault) |-> (l2_fault_va == walk_va && $stable(l1_fault_va) && rsp_pa == '0));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> (rsp_pa == walk_va && !rsp_l1_fault && !rsp_l2_fault));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_pa(rsp_pa), .rsp_l1_fault(rsp_l1_fault), .rsp_l2_fault(rsp_l2_fault),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_rd_data_valid(mem_rd_data_valid), .l1_fault_va(l1_fault_va),
  .l2_fault_va(l2_fault_va), .walk_va(walk_va), .rsp_bypass(rsp_bypass)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic [31:0] base_addr = 32'h8000_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_l1_fault, rsp_l2_fault, mem_rd_valid;
  logic [31:0] rsp_pa, mem_rd_addr, l1_fault_va, l2_fault_va;
  logic [3:0]  rsp_aci;
  logic        mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int errors = 0, checks = 0;
  int mem_lat = 0, wait_cnt = 0, served_cnt = 0;
  logic [31:0] served [2];
  logic [31:0] exp_l1 = '0, exp_l2 = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci),
    .rsp_l1_fault(rsp_l1_fault), .rsp_l2_fault(rsp_l2_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
    .l1_fault_va(l1_fault_va), .l2_fault_va(l2_fault_va)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Synthetic tables: directory entry d -> attr d%4, reserved bits set,
  // table pointer 0x4000_0000 + d*1024; page entry (d,j) -> frame {d,j},
  // aci j[3:0]^d[3:0], valid when j%3 != 0, reserved bits set.
  function automatic logic [31:0] table_word(input logic [31:0] a);
    logic [11:0] d;
    logic [7:0]  j;
    if (a[31:17] == 15'h4000) begin
      d = a[13:2];
      return 32'h4000_0000 | ({20'b0, d} << 10) | (32'hA5 << 2) | {30'b0, d[1:0]};
    end else if (a[31:22] == 10'h100) begin
      d = a[21:10];
      j = a[9:2];
      return {d, j, 4'hF, j[3:0] ^ d[3:0], 2'b11, (j % 3) != 0, 1'b1};
    end
    return 32'hDEAD_BEEF;
  endfunction

  always @(negedge clk) begin
    if (mem_rd_valid) begin
      if (wait_cnt >= mem_lat) begin
        mem_rd_data_valid <= 1'b1;
        mem_rd_data       <= table_word(mem_rd_addr);
        if (served_cnt < 2) served[served_cnt] = mem_rd_addr;
        served_cnt = served_cnt + 1;
        wait_cnt = 0;
      end else begin
        mem_rd_data_valid <= 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      mem_rd_data_valid <= 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic enb, input int lat,
                          input bit poke);
    logic [11:0] d;
    logic [7:0]  j;
    int n, exp_n, exp_reads;
    bit got;
    logic [31:0] e_pa;
    logic [3:0]  e_aci;
    logic e_l1, e_l2;
    d = va[31:20];
    j = va[19:12];
    mem_lat = lat;
    @(negedge clk);
    served_cnt = 0;
    chk(req_ready == 1'b1, "R8 ready before request", {31'b0, req_ready}, 32'd1);
    en = enb; req_valid = 1'b1; req_va = va;
    @(posedge clk);
    n = 0; got = 0;
    while (n < 100 && !got) begin
      @(negedge clk);
      n++;
      if (rsp_valid) got = 1;
      if (poke && !got) begin
        req_valid = 1'b1; req_va = ~va; en = ~enb;
      end else begin
        req_valid = 1'b0;
      end
    end
    e_l1 = 0; e_l2 = 0; e_pa = 0; e_aci = 0;
    if (!enb) begin
      e_pa = va; exp_n = 1; exp_reads = 0;
    end else if (d % 4 != 1) begin
      e_l1 = 1; exp_n = lat + 2; exp_reads = 1; exp_l1 = va;
    end else if (j % 3 == 0) begin
      e_l2 = 1; exp_n = 2*lat + 3; exp_reads = 2; exp_l2 = va;
    end else begin
      e_pa = {d, j, va[11:0]}; e_aci = j[3:0] ^ d[3:0];
      exp_n = 2*lat + 3; exp_reads = 2;
    end
    chk(got && n == exp_n, "R9 response latency", n, exp_n);
    chk(rsp_pa == e_pa, enb ? "R6 physical address" : "R7 bypass address", rsp_pa, e_pa);
    chk(rsp_aci == e_aci, "R6 authority index", {28'b0, rsp_aci}, {28'b0, e_aci});
    chk(rsp_l1_fault == e_l1, "R3 l1 fault flag", {31'b0, rsp_l1_fault}, {31'b0, e_l1});
    chk(rsp_l2_fault == e_l2, "R5 l2 fault flag", {31'b0, rsp_l2_fault}, {31'b0, e_l2});
    chk(served_cnt == exp_reads, enb ? "R3 read count" : "R7 no read in bypass", served_cnt, exp_reads);
    if (exp_reads >= 1)
      chk(served[0] == base_addr + {18'b0, d, 2'b00}, "R2 directory read address",
          served[0], base_addr + {18'b0, d, 2'b00});
    if (exp_reads == 2)
      chk(served[1] == 32'h4000_0000 + ({20'b0, d} << 10) + {22'b0, j, 2'b00},
          "R4 page entry read address", served[1],
          32'h4000_0000 + ({20'b0, d} << 10) + {22'b0, j, 2'b00});
    chk(l1_fault_va == exp_l1, "R3 l1 fault register", l1_fault_va, exp_l1);
    chk(l2_fault_va == exp_l2, "R5 l2 fault register", l2_fault_va, exp_l2);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single response pulse", {31'b0, rsp_valid}, 32'd0);
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int lats [3] = '{0, 1, 3};
    int js [5] = '{0, 1, 2, 5, 255};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1 reset response", {31'b0, rsp_valid}, 32'd0);
    chk(mem_rd_valid == 1'b0, "R1 reset read", {31'b0, mem_rd_valid}, 32'd0);
    chk(l1_fault_va == 0 && l2_fault_va == 0, "R1 reset fault registers", l1_fault_va | l2_fault_va, 32'd0);
    rst_n = 1'b1;
    for (int li = 0; li < 3; li++) begin
      base_addr = (li == 1) ? 32'h8001_0000 : 32'h8000_0000;
      for (int d = 0; d < 8; d++) begin
        for (int ji = 0; ji < 5; ji++) begin
          logic [11:0] off;
          off = 12'((d * 37 + js[ji] * 11 + li) & 12'hFFF);
          // R8: poke a second request during the walk when d == 5
          run_walk({12'(d), 8'(js[ji]), off}, 1'b1, lats[li], d == 5);
        end
      end
      run_walk({12'd4093, 8'd254, 12'hFFF}, 1'b1, lats[li], 1'b0);
      run_walk({12'd4095, 8'd1, 12'h000}, 1'b1, lats[li], 1'b0);
      run_walk({12'd4093, 8'd255, 12'h123}, 1'b1, lats[li], 1'b1);
    end
    // R7 bypass with varied addresses, including with a request poke
    run_walk(32'hFFFF_FFFF, 1'b0, 0, 1'b0);
    run_walk(32'h0000_0000, 1'b0, 2, 1'b0);
    run_walk(32'h1234_5678, 1'b0, 1, 1'b1);
    run_walk(32'h0010_2ABC, 1'b1, 2, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule